// File: doc/BRIEF.md
# Sixteen-Line GPIO Controller with Per-Line Interrupt Styles

The block is a general-purpose I/O controller for sixteen pads. Software controls it over a simple single-cycle register bus. Writes take effect at the clock edge and reads are combinational. Three registers cover the basic I/O:

- an output data register, which each pad drives when enabled;
- a direction register, where a set bit makes the line an input;
- a read-only input register, which returns the pad levels after a two-flop synchroniser.

Every line also has its own 3-bit trigger style. The styles are packed eight to a register across two style registers. A line can present a live active-high or active-low level, or it can latch a rising, falling or either-edge event into a sticky pending bit. Each line drives one active-high interrupt wire toward the CPU interrupt controller. Software clears latched edges by writing ones to the status register, and it changes a style by read-modify-write of the packed field.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the output register reads 0, the direction register reads 0xFFFF (all inputs), both style registers read 0, the status register reads 0, `pad_oe` is 0 and `irq_out` is 0.
- R2: Word addresses are 0 = output data, 1 = direction, 2 = input, 3 = styles for lines 0..7, 4 = styles for lines 8..15, 5 = status. A direction bit of 1 makes that line an input (`pad_oe` bit 0), and a 0 drives the output register bit onto `pad_out`. Output and direction read back as written.
- R3: The input register (address 2) shows a pad level change on the second clock edge after the change and not on the first.
- R4: Line n's style field is bits [3·(n mod 8)+2 : 3·(n mod 8)] of style register 3 (n < 8) or 4 (n ≥ 8). Bits 23..0 read back exactly as written and bits 31..24 read 0.
- R5: Style 0 presents the synchronised pad level live on `irq_out[n]`, and style 1 presents its inverse.
- R6: Styles 2 (rising), 3 (falling) and 4 (either edge) set a sticky pending bit on the matching change of the synchronised level, and `irq_out[n]` follows that bit.
- R7: Writing 1 to status bit n clears the pending edge of line n. For level styles the write has no effect on `irq_out[n]`.
- R8: Styles 5, 6 and 7 never raise `irq_out[n]` for any pad activity.
- R9: A style write that changes line n's code clears its pending edge. A write that leaves the code unchanged keeps the pending edge.
- R10: Reading the status register (address 5) returns `irq_out` in bits 15..0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Access is a write when high |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| pad_in | input | 16 | Asynchronous pad levels |
| pad_out | output | 16 | Output data toward pads |
| pad_oe | output | 16 | Per-pad drive enable, high = driving |
| irq_out | output | 16 | Active-high interrupt per line |

## Verification
Every one of the eight style codes is applied to every line in turn. Each is run through four steps: pad held low, a rising pad step, a status clear while the pad is still high, and a falling pad step. These four steps separate level from edge styles, rising from falling, either-edge from both, and reserved codes from all the others. They also show that a clear removes a latched edge but leaves a live level alone. A separate sequence rewrites a latched line's style with the same code and then with a different code, to tell the clear-on-change rule apart from a clear on any write. Several input patterns, sampled one and then two clocks after a pad change, pin down the synchroniser latency.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int STYLE_W       = 3;
    localparam int LINES_PER_REG = 8;

    typedef logic [STYLE_W-1:0] style_t;

    localparam style_t STY_HIGH = 3'd0;
    localparam style_t STY_LOW  = 3'd1;
    localparam style_t STY_RISE = 3'd2;
    localparam style_t STY_FALL = 3'd3;
    localparam style_t STY_ANY  = 3'd4;

    localparam int A_OUT  = 0;
    localparam int A_DIR  = 1;
    localparam int A_IN   = 2;
    localparam int A_STY0 = 3;
    localparam int A_STAT = 5;

    function automatic logic is_level(style_t s);
        return (s == STY_HIGH) || (s == STY_LOW);
    endfunction

    function automatic logic level_val(style_t s, logic cur);
        return (s == STY_LOW) ? ~cur : cur;
    endfunction

    function automatic logic edge_hit(style_t s, logic cur, logic prev);
        case (s)
            STY_RISE: return cur & ~prev;
            STY_FALL: return ~cur & prev;
            STY_ANY:  return cur ^ prev;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pad_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] prev_o
);
    logic [WIDTH-1:0] meta_q;
    logic [1:0]       age_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_o <= '0;
            prev_o <= '0;
            age_q  <= '0;
        end else begin
            meta_q <= pad_i;
            sync_o <= meta_q;
            prev_o <= sync_o;
            if (age_q != 2'd3) age_q <= age_q + 2'd1;
        end
    end

    AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd2) |-> (sync_o == $past(pad_i, 2)));   // R3

    AST_PREV_ONE_BEHIND: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd1) |-> (prev_o == $past(sync_o)));     // R6

endmodule

// File: rtl/gpio_line_irq.sv
module gpio_line_irq
    import gpio_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  style_t style,
    input  logic   cur,
    input  logic   prev,
    input  logic   clr,
    input  logic   restyle,
    output logic   irq
);
    logic pend_q;
    logic hit;

    assign hit = edge_hit(style, cur, prev);

    always_ff @(posedge clk) begin
        if (rst)          pend_q <= 1'b0;
        else if (restyle) pend_q <= 1'b0;
        else if (hit)     pend_q <= 1'b1;
        else if (clr)     pend_q <= 1'b0;
    end

    always_comb begin
        if (is_level(style)) irq = level_val(style, cur);
        else                 irq = pend_q;
    end

    AST_PEND_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q) |-> $past(cur != prev));              // R6

    AST_RESTYLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (style != $past(style)) |-> !pend_q);               // R9

    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
        (pend_q && clr && !hit && !restyle) |=> !pend_q);   // R7

    AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (style > STY_ANY) |-> !irq);                        // R8

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_LINES-1:0] pad_in,
    output logic [NUM_LINES-1:0] pad_out,
    output logic [NUM_LINES-1:0] pad_oe,
    output logic [NUM_LINES-1:0] irq_out
);
    localparam int STY_BITS = STYLE_W * LINES_PER_REG;

    logic                 wr;
    logic [NUM_LINES-1:0] out_q;
    logic [NUM_LINES-1:0] dir_q;
    logic [NUM_LINES-1:0] sync_v;
    logic [NUM_LINES-1:0] prev_v;
    style_t               style_q [NUM_LINES];
    logic                 unused_wdata_hi;

    assign wr              = bus_sel & bus_wr;
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:STY_BITS];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            dir_q <= '1;
        end else if (wr) begin
            if (bus_addr == ADDR_W'(A_OUT)) out_q <= bus_wdata[NUM_LINES-1:0];
            if (bus_addr == ADDR_W'(A_DIR)) dir_q <= bus_wdata[NUM_LINES-1:0];
        end
    end

    assign pad_out = out_q;
    assign pad_oe  = ~dir_q;

    gpio_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pad_i  (pad_in),
        .sync_o (sync_v),
        .prev_o (prev_v)
    );

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        localparam int FIELD_LSB = STYLE_W * (n % LINES_PER_REG);
        localparam int REG_ADDR  = A_STY0 + n / LINES_PER_REG;

        style_t new_style;
        logic   sty_wr;
        logic   restyle;
        logic   clr;

        assign new_style = bus_wdata[FIELD_LSB +: STYLE_W];
        assign sty_wr    = wr && (bus_addr == ADDR_W'(REG_ADDR));
        assign restyle   = sty_wr && (new_style != style_q[n]);
        assign clr       = wr && (bus_addr == ADDR_W'(A_STAT)) && bus_wdata[n];

        always_ff @(posedge clk) begin
            if (rst)         style_q[n] <= STY_HIGH;
            else if (sty_wr) style_q[n] <= new_style;
        end

        gpio_line_irq u_irq (
            .clk     (clk),
            .rst     (rst),
            .style   (style_q[n]),
            .cur     (sync_v[n]),
            .prev    (prev_v[n]),
            .clr     (clr),
            .restyle (restyle),
            .irq     (irq_out[n])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(A_OUT))  bus_rdata[NUM_LINES-1:0] = out_q;
        if (bus_addr == ADDR_W'(A_DIR))  bus_rdata[NUM_LINES-1:0] = dir_q;
        if (bus_addr == ADDR_W'(A_IN))   bus_rdata[NUM_LINES-1:0] = sync_v;
        if (bus_addr == ADDR_W'(A_STAT)) bus_rdata[NUM_LINES-1:0] = irq_out;
        for (int n = 0; n < NUM_LINES; n++) begin
            if (bus_addr == ADDR_W'(A_STY0 + n / LINES_PER_REG))
                bus_rdata[STYLE_W*(n % LINES_PER_REG) +: STYLE_W] = style_q[n];
        end
    end

    AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (rst)
        $past(wr && bus_addr == ADDR_W'(A_DIR)) |->
            (pad_oe == ~$past(bus_wdata[NUM_LINES-1:0])));  // R2

endmodule

// File: tb/tb_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_sel, bus_wr;
    logic [2:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [15:0] pad_in, pad_out, pad_oe, irq_out;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    always #2 clk = ~clk;

    gpio_irq_ctrl dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic settle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    function automatic string tag_of(input int c);
        if (c < 2) return "R5";
        if (c < 5) return "R6";
        return "R8";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] pat;
        rst = 1; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; pad_in = 0;
        settle(3);
        rst = 0;
        settle(1);

        // R1 reset state
        rd(3'd0, v); chk("R1 out", v, 32'h0);
        rd(3'd1, v); chk("R1 dir", v, 32'h0000FFFF);
        rd(3'd3, v); chk("R1 sty0", v, 32'h0);
        rd(3'd4, v); chk("R1 sty1", v, 32'h0);
        rd(3'd5, v); chk("R1 status", v, 32'h0);
        chk("R1 pad_oe", {16'h0, pad_oe}, 32'h0);
        chk("R1 irq", {16'h0, irq_out}, 32'h0);

        // R2 direction and output
        wr(3'd1, 32'h000000F0);
        chk("R2 pad_oe", {16'h0, pad_oe}, 32'h0000FF0F);
        wr(3'd0, 32'h0000A5C3);
        chk("R2 pad_out", {16'h0, pad_out}, 32'h0000A5C3);
        rd(3'd1, v); chk("R2 dir rb", v, 32'h000000F0);
        rd(3'd0, v); chk("R2 out rb", v, 32'h0000A5C3);
        wr(3'd1, 32'h0000FFFF);
        chk("R2 all input", {16'h0, pad_oe}, 32'h0);

        // R3 two-stage input latency
        for (int p = 0; p < 4; p++) begin
            logic [15:0] old_v, new_v;
            old_v = pad_in;
            new_v = 16'(32'h1234 * (p + 3) ^ 32'h5A5A);
            pad_in = new_v;
            @(negedge clk);
            rd(3'd2, v); chk("R3 after one edge", v, {16'h0, old_v});
            @(negedge clk);
            rd(3'd2, v); chk("R3 after two edges", v, {16'h0, new_v});
        end
        pad_in = 0;
        settle(4);

        // R4 style field readback
        pat = 0;
        for (int n = 0; n < 8; n++) pat |= ((n * 5 + 3) % 8) << (3 * n);
        wr(3'd3, pat | 32'hFF000000);
        rd(3'd3, v); chk("R4 sty0 rb", v, pat);
        pat = 0;
        for (int n = 8; n < 16; n++) pat |= ((n * 3 + 1) % 8) << (3 * (n % 8));
        wr(3'd4, pat | 32'hAB000000);
        rd(3'd4, v); chk("R4 sty1 rb", v, pat);
        wr(3'd3, 0);
        wr(3'd4, 0);
        wr(3'd5, 32'hFFFF);
        settle(4);

        // R5..R8, R10: every style on every line through four steps
        for (int L = 0; L < 16; L++) begin
            for (int c = 0; c < 8; c++) begin
                logic [31:0] f;
                logic e;
                string t;
                t = tag_of(c);
                f = 32'(c) << (3 * (L % 8));
                wr(3'd3, (L < 8) ? f : 32'h0);
                wr(3'd4, (L < 8) ? 32'h0 : f);
                wr(3'd5, 32'hFFFF);
                e = (c == 1);
                chk({t, " low"}, {16'h0, irq_out}, 32'(e) << L);
                pad_in = 16'(1) << L;
                settle(4);
                e = (c == 0) || (c == 2) || (c == 4);
                chk({t, " rise"}, {16'h0, irq_out}, 32'(e) << L);
                rd(3'd5, v); chk("R10 status", v, 32'(e) << L);
                wr(3'd5, 32'(1) << L);
                e = (c == 0);
                chk("R7 clear", {16'h0, irq_out}, 32'(e) << L);
                pad_in = 0;
                settle(4);
                e = (c == 1) || (c == 3) || (c == 4);
                chk({t, " fall"}, {16'h0, irq_out}, 32'(e) << L);
                wr(3'd5, 32'hFFFF);
            end
        end
        wr(3'd3, 0);
        wr(3'd4, 0);
        wr(3'd5, 32'hFFFF);

        // R9 style change vs same-code rewrite on line 5
        wr(3'd3, 32'(2) << 15);
        pad_in = 16'h0020;
        settle(4);
        chk("R9 latched", {16'h0, irq_out}, 32'h0020);
        wr(3'd3, 32'(2) << 15);
        chk("R9 same code keeps", {16'h0, irq_out}, 32'h0020);
        wr(3'd3, 32'(4) << 15);
        chk("R9 new code clears", {16'h0, irq_out}, 32'h0);
        pad_in = 0;
        settle(4);
        chk("R9 still live", {16'h0, irq_out}, 32'h0020);

        done = 1;
        summary();
    end

endmodule